// File: doc/BRIEF.md
# Edge/Level Sensing Interrupt Bank

This block gathers 32 active-low interrupt lines into one bank and turns them into two processor requests, a normal request (`irq_out`) and a fast request (`fiq_out`). Each line is set up on its own as falling-edge or low-level sensitive. It is also given a priority and a route to one of the two outputs. An input transition sets a pending bit. Software can also raise a line through a trigger register, and can clear pending bits by writing a keep-mask.

The two request paths work the same way. While a path is armed and at least one unmasked pending line is routed to it, the path picks a winning line. It latches that line number, raises its output and disarms. The output stays high until software re-arms the path through the control register. Reading the path's vector register returns the latched line. If that line is edge-sensitive, the read also clears its pending bit, so the usual service sequence is to read the vector, handle the line and then re-arm.

The register interface accepts single 32-bit reads and writes. Every access completes in its own cycle, so there is no back-pressure. Read data is combinational on the cycle `bus_rd` is high, and any side effect of the read takes place at the clock edge that ends that cycle. The bank answers only when address bits [9:8] equal `BANK_SEL`.

Top module: `intr_sense_bank`

## Requirements
- R1: After reset, the mask register reads 0xFFFFFFFF. The pending register, every line register and both vector registers read zero, and `irq_out` and `fiq_out` are low.
- R2: The line register of line n is at offset 0x1C+4n. Bits [6:2] hold the priority, bit 1 holds the sensitivity (0 = edge, 1 = level) and bit 0 holds the route (0 = `irq_out`, 1 = `fiq_out`). All other bits are discarded on write and read as zero.
- R3: A line is active while `line_n` is low. For an edge line, the pending bit is set when the line is sampled active and its stored input state was inactive. Holding the line active does not set the bit again.
- R4: A level line sets its pending bit in every cycle it is sampled active. The bit clears when the line is sampled inactive after having been active.
- R5: Offset 0x00 reads the pending bits. A write there ANDs the pending bits with the written data, except that a level line whose input is active keeps its bit.
- R6: Offset 0x04 is the mask register, and a 1 masks the line. A masked line stays visible at 0x00 but can never be chosen or raise an output.
- R7: Writing 1 to bit n at offset 0x08 triggers line n in software. An edge line becomes pending only if its stored input state is inactive, and a level line always becomes pending. Offset 0x08 reads zero.
- R8: Among the unmasked pending lines routed to a path, the winner is the line with the lowest priority value. On equal priority, the higher line number wins.
- R9: When a path is armed and has an eligible line, its output rises at the next edge and the winner is latched. Writing bit 0 (normal path) or bit 1 (fast path) at offset 0x18 drops that output at the next edge and re-arms the path. The other path is not affected.
- R10: Offsets 0x10 (normal) and 0x14 (fast) read the latched line in bits [4:0]. The read clears that line's pending bit if the line is edge-sensitive and leaves a level line's bit alone.
- R11: Accesses whose address bits [9:8] differ from `BANK_SEL`, and accesses to unmapped offsets such as 0x0C, read zero and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_n | input | NLINES | Interrupt lines, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; [9:8] select the bank, [7:0] the offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
Arbitration is swept over forty software-triggered patterns of two or three lines. The priority table repeats every eight lines, so some patterns separate lines by priority value and others fall back to the line-number tie-break. After each winner is read back, the pending register is checked to confirm that only the winner's bit was acknowledged. Separate hold/release sequences on one edge line and one level line distinguish single capture from continuous capture. They also show when a write-clear or a vector read is honoured and when it is refused. A mixed pattern with fast-routed and masked lines shows that each path chooses only from its own unmasked lines and is re-armed on its own.

// File: rtl/isb_pkg.sv
package isb_pkg;
  localparam logic [7:0] OFS_PEND  = 8'h00;
  localparam logic [7:0] OFS_MASK  = 8'h04;
  localparam logic [7:0] OFS_SWTRG = 8'h08;
  localparam logic [7:0] OFS_VNORM = 8'h10;
  localparam logic [7:0] OFS_VFAST = 8'h14;
  localparam logic [7:0] OFS_CTRL  = 8'h18;
  localparam logic [7:0] OFS_LINE0 = 8'h1C;
  localparam int unsigned NPATHS = 2;  // path 0 normal, path 1 fast
endpackage

// File: rtl/isb_cfg_regs.sv
module isb_cfg_regs #(
  parameter int unsigned NLINES = 32,
  parameter int unsigned PRIO_W = 5,
  parameter int unsigned LINE_W = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           mask_wr,
  input  logic [NLINES-1:0]              mask_d,
  input  logic                           lvl_wr,
  input  logic [LINE_W-1:0]              lvl_idx,
  input  logic [PRIO_W-1:0]              lvl_prio,
  input  logic                           lvl_sens,
  input  logic                           lvl_route,
  output logic [NLINES-1:0]              mask,
  output logic [NLINES-1:0][PRIO_W-1:0]  prio,
  output logic [NLINES-1:0]              sens,
  output logic [NLINES-1:0]              route
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask  <= '1;
      prio  <= '0;
      sens  <= '0;
      route <= '0;
    end else begin
      if (mask_wr) mask <= mask_d;
      if (lvl_wr) begin
        prio[lvl_idx]  <= lvl_prio;
        sens[lvl_idx]  <= lvl_sens;
        route[lvl_idx] <= lvl_route;
      end
    end
  end
endmodule

// File: rtl/isb_capture.sv
module isb_capture #(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] act,      // line currently asserted
  input  logic [NLINES-1:0] sens,     // 1 = level
  input  logic [NLINES-1:0] trig,     // software trigger this cycle
  input  logic              clr_wr,
  input  logic [NLINES-1:0] clr_keep,
  input  logic [NLINES-1:0] ack,      // vector read of these lines
  output logic [NLINES-1:0] pend
);
  logic [NLINES-1:0] inp_q, keep, set_v, fall, pend_d;

  always_comb begin
    keep   = clr_wr ? (clr_keep | (sens & act)) : '1;
    set_v  = (~sens & (act | trig) & ~inp_q) | (sens & (act | trig));
    fall   = sens & inp_q & ~act;
    pend_d = ((pend & keep & ~(ack & ~sens)) | set_v) & ~fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      inp_q <= '0;
    end else begin
      pend  <= pend_d;
      inp_q <= act;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_chk
    AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sens[i] && inp_q[i] && !pend[i]) |=> !pend[i]); // R3
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sens[i] && act[i]) |=> pend[i]); // R4
    AST_LEVEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (sens[i] && inp_q[i] && !act[i]) |=> !pend[i]); // R4
  end
endmodule

// File: rtl/isb_arbiter.sv
module isb_arbiter #(
  parameter int unsigned NLINES = 32,
  parameter int unsigned PRIO_W = 5,
  parameter int unsigned LINE_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NLINES-1:0]             elig,
  input  logic [NLINES-1:0][PRIO_W-1:0] prio,
  input  logic                          rearm,
  output logic                          req_out,
  output logic [LINE_W-1:0]             vec
);
  logic              armed_q, found;
  logic [PRIO_W-1:0] best_p;
  logic [LINE_W-1:0] best_i;

  // lowest value wins; scanning upward with <= lets the higher line take ties
  always_comb begin
    found  = 1'b0;
    best_p = '1;
    best_i = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (elig[i] && (!found || prio[i] <= best_p)) begin
        found  = 1'b1;
        best_p = prio[i];
        best_i = LINE_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      req_out <= 1'b0;
      vec     <= '0;
    end else if (rearm) begin
      armed_q <= 1'b1;
      req_out <= 1'b0;
    end else if (armed_q && found) begin
      armed_q <= 1'b0;
      req_out <= 1'b1;
      vec     <= best_i;
    end
  end

  AST_REARM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !req_out); // R9
  AST_RISE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_out) |-> $past(armed_q)); // R9
  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_out) |-> (($past(elig) >> vec) & NLINES'(1)) != '0); // R8
endmodule

// File: rtl/intr_sense_bank.sv
module intr_sense_bank
  import isb_pkg::*;
#(
  parameter int unsigned NLINES   = 32,
  parameter int unsigned PRIO_W   = 5,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned BANK_SEL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out,
  output logic              fiq_out
);
  localparam int unsigned LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1;

  logic                          hit, lvl_hit;
  logic [7:0]                    ofs, lvl_diff;
  logic [LINE_W-1:0]             lvl_idx;
  logic [NLINES-1:0]             act, mask, sens, route, pend, trig, ack;
  logic [NLINES-1:0][PRIO_W-1:0] prio;
  logic [NPATHS-1:0][NLINES-1:0] elig;
  logic [NPATHS-1:0]             rearm, req;
  logic [NPATHS-1:0][LINE_W-1:0] vec;

  assign act      = ~line_n;
  assign hit      = (bus_addr >> 8) == ADDR_W'(BANK_SEL);
  assign ofs      = bus_addr[7:0];
  assign lvl_diff = ofs - OFS_LINE0;
  assign lvl_idx  = LINE_W'(lvl_diff >> 2);
  assign lvl_hit  = hit && (ofs >= OFS_LINE0) && (lvl_diff[1:0] == 2'b00)
                    && (32'(lvl_diff >> 2) < NLINES);
  assign trig     = (bus_wr && hit && ofs == OFS_SWTRG) ? bus_wdata[NLINES-1:0] : '0;

  always_comb begin
    ack = '0;
    if (bus_rd && hit && ofs == OFS_VNORM) ack = ack | (NLINES'(1) << vec[0]);
    if (bus_rd && hit && ofs == OFS_VFAST) ack = ack | (NLINES'(1) << vec[1]);
  end

  isb_cfg_regs #(.NLINES(NLINES), .PRIO_W(PRIO_W), .LINE_W(LINE_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_wr   (bus_wr && hit && ofs == OFS_MASK),
    .mask_d    (bus_wdata[NLINES-1:0]),
    .lvl_wr    (bus_wr && lvl_hit),
    .lvl_idx   (lvl_idx),
    .lvl_prio  (bus_wdata[PRIO_W+1:2]),
    .lvl_sens  (bus_wdata[1]),
    .lvl_route (bus_wdata[0]),
    .mask      (mask),
    .prio      (prio),
    .sens      (sens),
    .route     (route)
  );

  isb_capture #(.NLINES(NLINES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .sens     (sens),
    .trig     (trig),
    .clr_wr   (bus_wr && hit && ofs == OFS_PEND),
    .clr_keep (bus_wdata[NLINES-1:0]),
    .ack      (ack),
    .pend     (pend)
  );

  for (genvar k = 0; k < NPATHS; k++) begin : g_path
    assign elig[k]  = pend & ~mask & (k == 1 ? route : ~route);
    assign rearm[k] = bus_wr && hit && ofs == OFS_CTRL && bus_wdata[k];
    isb_arbiter #(.NLINES(NLINES), .PRIO_W(PRIO_W), .LINE_W(LINE_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .elig    (elig[k]),
      .prio    (prio),
      .rearm   (rearm[k]),
      .req_out (req[k]),
      .vec     (vec[k])
    );
  end

  assign irq_out = req[0];
  assign fiq_out = req[1];

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (ofs)
        OFS_PEND:  bus_rdata = 32'(pend);
        OFS_MASK:  bus_rdata = 32'(mask);
        OFS_VNORM: bus_rdata = 32'(vec[0]);
        OFS_VFAST: bus_rdata = 32'(vec[1]);
        default:
          if (lvl_hit) bus_rdata = 32'({prio[lvl_idx], sens[lvl_idx], route[lvl_idx]});
      endcase
    end
  end

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1 && !irq_out) |=> !irq_out); // R6
  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit) |=> $stable(mask)); // R11
endmodule

// File: tb/intr_sense_bank_test.sv
module intr_sense_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] line_n = '1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] d;

  always #10 clk = ~clk;  // 50 MHz

  intr_sense_bank uut (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int pr(int i);
    return (i * 3) % 8;
  endfunction

  function automatic int winner(logic [31:0] s);
    int b = -1;
    for (int i = 0; i < 32; i++)
      if (s[i] && (b < 0 || pr(i) <= pr(b))) b = i;
    return b;
  endfunction

  initial begin
    #(100000 * 20);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3); rst_n = 1'b1; step(1);
    // R1 reset state
    rd(10'h000, d); check("R1 pending", d, 32'h0);
    rd(10'h004, d); check("R1 mask", d, 32'hFFFF_FFFF);
    rd(10'h098, d); check("R1 line31 reg", d, 32'h0);
    rd(10'h010, d); check("R1 vector", d, 32'h0);
    check("R1 outputs", {30'h0, irq_out, fiq_out}, 32'h0);

    // R2 field packing
    wr(10'h040, 32'hFFFF_FFFF); rd(10'h040, d); check("R2 line9 all ones", d, 32'h7F);
    for (int i = 0; i < 32; i++) begin
      wr(10'(8'h1C + 4 * i), 32'hFFFF_FF80 | 32'(pr(i) << 2));
      rd(10'(8'h1C + 4 * i), d); check("R2 line reg", d, 32'(pr(i) << 2));
    end
    wr(10'h004, 32'h0); rd(10'h004, d); check("R6 mask cleared", d, 32'h0);

    // R3 edge capture
    line_n[5] = 1'b0; step(2);
    rd(10'h000, d); check("R3 edge set", d, 32'h20);
    check("R9 first fire", {31'h0, irq_out}, 32'h1);
    rd(10'h010, d); check("R10 vector edge", d, 32'd5);
    rd(10'h000, d); check("R10 R3 ack clear, held no repeat", d, 32'h0);
    line_n[5] = 1'b1; step(1); line_n[5] = 1'b0; step(2);
    rd(10'h000, d); check("R3 re-edge", d, 32'h20);
    line_n[5] = 1'b1; wr(10'h000, 32'h0);
    rd(10'h000, d); check("R5 edge clear", d, 32'h0);

    // R4/R5 level line 6
    wr(10'h034, 32'(pr(6) << 2) | 32'h2);
    line_n[6] = 1'b0; step(2);
    rd(10'h000, d); check("R4 level set", d, 32'h40);
    wr(10'h000, 32'h0);
    rd(10'h000, d); check("R5 level kept", d, 32'h40);
    wr(10'h018, 32'h1);
    rd(10'h010, d); check("R9 refire vector", d, 32'd6);
    rd(10'h000, d); check("R10 level not acked", d, 32'h40);
    line_n[6] = 1'b1; step(2);
    rd(10'h000, d); check("R4 release clears", d, 32'h0);
    wr(10'h034, 32'(pr(6) << 2));

    // R11 unmapped and foreign bank
    rd(10'h00C, d); check("R11 unmapped read", d, 32'h0);
    wr(10'h00C, 32'hFFFF_FFFF);
    wr(10'h104, 32'hFFFF_FFFF);
    rd(10'h004, d); check("R11 mask unchanged", d, 32'h0);
    rd(10'h110, d); check("R11 foreign vector", d, 32'h0);
    rd(10'h000, d); check("R11 pending unchanged", d, 32'h0);

    // R7 software trigger
    wr(10'h008, 32'h1000);
    rd(10'h008, d); check("R7 reads zero", d, 32'h0);
    rd(10'h000, d); check("R7 trigger sets", d, 32'h1000);

    // R8/R9/R10 arbitration sweep
    for (int t = 0; t < 40; t++) begin
      logic [31:0] patt;
      int w;
      patt = (32'h1 << (t % 32)) | (32'h1 << ((t * 7 + 3) % 32));
      if (t % 3 == 0) patt = patt | (32'h1 << ((t * 11 + 5) % 32));
      w = winner(patt);
      wr(10'h000, 32'h0);
      wr(10'h008, patt);
      wr(10'h018, 32'h1);
      check("R9 drop on rearm", {31'h0, irq_out}, 32'h0);
      step(1);
      check("R9 rise", {31'h0, irq_out}, 32'h1);
      rd(10'h010, d); check("R8 winner", d, 32'(w));
      rd(10'h000, d); check("R10 only winner acked", d, patt & ~(32'h1 << w));
    end

    // R6/R9 fast path with mask
    wr(10'h000, 32'h0);
    wr(10'h06C, 32'(pr(20) << 2) | 32'h1);
    wr(10'h070, 32'(pr(21) << 2) | 32'h1);
    wr(10'h004, 32'h0020_0000);
    wr(10'h008, 32'h4030_0002);
    wr(10'h018, 32'h3);
    step(1);
    check("R9 fast rise", {31'h0, fiq_out}, 32'h1);
    rd(10'h014, d); check("R6 masked skipped fast", d, 32'd20);
    rd(10'h010, d); check("R8 normal excludes fast", d, 32'd30);
    rd(10'h000, d); check("R6 masked still pending", d, 32'h0020_0002);
    wr(10'h004, 32'h0);
    wr(10'h018, 32'h2);
    check("R9 normal untouched", {30'h0, irq_out, fiq_out}, 32'h2);
    step(1);
    rd(10'h014, d); check("R9 fast refire", d, 32'd21);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule